// File: doc/BRIEF.md
# One-Second Strobe Generator with Clock-Source Failover

This block produces a periodic one-second strobe for performance monitoring across a set of framer channels. Everything runs on one fast system clock. Each channel presents a one-cycle enable for every edge of its receive line clock, a flag that says the clock has gone missing, and a strap that tells whether the channel runs the 1.544 MHz rate or the 2.048 MHz rate. The block takes one channel's enables as its timebase. It counts them up to that channel's per-second edge count and then raises a single-cycle master strobe.

After reset the timebase is channel 0. When the timebase channel reports a lost clock, the block moves to the next higher channel whose clock is present, wrapping past the last channel. The running count is kept across the move, so the one-second cadence carries on without an extra strobe. Every channel then carries the master strobe over into its own clock domain: its own output rises on its next clock enable and falls on the enable after that.

Top module: `sec_pulse_gen`

## Requirements
- R1: `master_pulse` is high for exactly one system-clock cycle, one cycle after the timebase enable that completes a full count of the active terminal value. With no source change, consecutive master pulses are exactly that many source enables apart.
- R2: The terminal value comes from the current source channel's strap. When `ch_mode_ds1` is 1 it is `DS1_COUNT`; when it is 0 it is `CEPT_COUNT`.
- R3: While `rst` is high at a clock edge, the count clears, `active_src` becomes 0, and `master_pulse` and every `ch_pulse` bit go low.
- R4: When `ch_loss[active_src]` is 1 and at least one channel is still clocked, `active_src` moves on the next edge to the first unlost channel counting upward from `active_src`+1 and wrapping past `NUM_CH`-1 to 0. While the source keeps its clock, `active_src` does not change, and it does not return to channel 0 when channel 0 recovers.
- R5: When every `ch_loss` bit is 1, `all_lost` is high, the count holds its value, no master pulse is produced and `active_src` keeps its value. Counting resumes from the held value once a clock comes back.
- R6: A change of source does not clear the count. An enable from a lost source is not counted. If the held count already meets or exceeds the new source's terminal value minus one, the first enable of the new source gives exactly one master pulse and restarts the count from 0.
- R7: `ch_pulse[i]` goes high on the first `ch_clk_en[i]` edge that comes strictly after a master pulse cycle. It stays high until the following `ch_clk_en[i]` edge, and each master pulse raises it only once. It changes only on edges where `ch_clk_en[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_clk_en | input | NUM_CH | Per-channel receive clock edge enable, one cycle per line clock edge |
| ch_loss | input | NUM_CH | Per-channel loss-of-clock flag |
| ch_mode_ds1 | input | NUM_CH | Per-channel rate strap: 1 selects 1.544 MHz count, 0 selects 2.048 MHz count |
| master_pulse | output | 1 | One-cycle one-second strobe in the system domain |
| ch_pulse | output | NUM_CH | Per-channel strobe retimed to that channel's clock enables |
| active_src | output | $clog2(NUM_CH) | Index of the channel currently used as timebase |
| all_lost | output | 1 | High while every channel reports a lost clock |

## Verification
First, with every channel enabled on every cycle, the bench measures the spacing between pulses on each strap setting, which separates the two terminal values. Random enable densities and random straps show that only the source channel's enables and strap drive the count, while the other channels' enables only move their own retimed outputs. Directed loss patterns fix the failover order: a single step, a skip over two lost channels, a wrap back to channel 0, no return after recovery, and a total outage that must freeze the count. A source move made late in a long count, and a later phase of random loss churn, check that the count carried across a move gives one pulse and never two.

// File: rtl/spg_pkg.sv
`timescale 1ns/1ps
package spg_pkg;
   // larger of two terminal counts, used to size the shared counter
   function automatic int unsigned spg_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // counter width able to hold values 0 .. term-1
   function automatic int unsigned spg_cnt_width(input int unsigned term);
      return (term < 2) ? 1 : $clog2(term);
   endfunction
endpackage

// File: rtl/spg_src_select.sv
`timescale 1ns/1ps
module spg_src_select #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] ch_loss,
   output logic [IDX_W-1:0]  sel_q,
   output logic              all_lost
);
   logic [IDX_W-1:0] sel_d;
   logic             found;
   int               cand;

   // upward search from the current source, wrapping at NUM_CH
   always_comb begin
      all_lost = &ch_loss;
      sel_d    = sel_q;
      found    = 1'b0;
      cand     = 0;
      if (ch_loss[sel_q] && !all_lost) begin
         for (int k = 1; k < NUM_CH; k++) begin
            cand = int'(sel_q) + k;
            if (cand >= NUM_CH) cand = cand - NUM_CH;
            if (!found && !ch_loss[cand]) begin
               sel_d = IDX_W'(cand);
               found = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) sel_q <= '0;
      else     sel_q <= sel_d;
   end
endmodule

// File: rtl/spg_timebase.sv
`timescale 1ns/1ps
module spg_timebase #(
   parameter int NUM_CH     = 8,
   parameter int IDX_W      = 3,
   parameter int CNT_W      = 21,
   parameter int DS1_COUNT  = 1544000,
   parameter int CEPT_COUNT = 2048000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] ch_clk_en,
   input  logic [NUM_CH-1:0] ch_loss,
   input  logic [NUM_CH-1:0] ch_mode_ds1,
   input  logic [IDX_W-1:0]  sel,
   output logic              master_pulse
);
   localparam logic [CNT_W-1:0] DS1_LAST  = CNT_W'(DS1_COUNT - 1);
   localparam logic [CNT_W-1:0] CEPT_LAST = CNT_W'(CEPT_COUNT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             tick;
   logic             wrap;

   // a lost source contributes no edges; the terminal follows the live strap
   always_comb begin
      tick = ch_clk_en[sel] & ~ch_loss[sel];
      last = ch_mode_ds1[sel] ? DS1_LAST : CEPT_LAST;
      wrap = tick && (cnt_q >= last);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q        <= '0;
         master_pulse <= 1'b0;
      end else begin
         master_pulse <= wrap;
         if (wrap)      cnt_q <= '0;
         else if (tick) cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/spg_retime.sv
`timescale 1ns/1ps
module spg_retime (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic master_pulse,
   output logic pulse_out
);
   logic pend_q;

   // pending flag bridges the system-domain strobe to the next channel edge
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q    <= 1'b0;
         pulse_out <= 1'b0;
      end else if (strobe) begin
         pulse_out <= pend_q;
         pend_q    <= master_pulse;
      end else begin
         pend_q    <= pend_q | master_pulse;
      end
   end
endmodule

// File: rtl/sec_pulse_gen.sv
`timescale 1ns/1ps
module sec_pulse_gen
   import spg_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int DS1_COUNT  = 1544000,
   parameter int CEPT_COUNT = 2048000,
   localparam int IDX_W     = $clog2(NUM_CH),
   localparam int MAX_TERM  = int'(spg_max(DS1_COUNT, CEPT_COUNT)),
   localparam int CNT_W     = int'(spg_cnt_width(MAX_TERM))
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] ch_clk_en,
   input  logic [NUM_CH-1:0] ch_loss,
   input  logic [NUM_CH-1:0] ch_mode_ds1,
   output logic              master_pulse,
   output logic [NUM_CH-1:0] ch_pulse,
   output logic [IDX_W-1:0]  active_src,
   output logic              all_lost
);
   generate
      if (NUM_CH < 2) begin : g_bad_num_ch
         $error("sec_pulse_gen: NUM_CH must be at least 2");
      end
      if (DS1_COUNT < 2) begin : g_bad_ds1
         $error("sec_pulse_gen: DS1_COUNT must be at least 2");
      end
      if (CEPT_COUNT < 2) begin : g_bad_cept
         $error("sec_pulse_gen: CEPT_COUNT must be at least 2");
      end
   endgenerate

   spg_src_select #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W)
   ) u_sel (
      .clk      (clk),
      .rst      (rst),
      .ch_loss  (ch_loss),
      .sel_q    (active_src),
      .all_lost (all_lost)
   );

   spg_timebase #(
      .NUM_CH     (NUM_CH),
      .IDX_W      (IDX_W),
      .CNT_W      (CNT_W),
      .DS1_COUNT  (DS1_COUNT),
      .CEPT_COUNT (CEPT_COUNT)
   ) u_tb (
      .clk          (clk),
      .rst          (rst),
      .ch_clk_en    (ch_clk_en),
      .ch_loss      (ch_loss),
      .ch_mode_ds1  (ch_mode_ds1),
      .sel          (active_src),
      .master_pulse (master_pulse)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      spg_retime u_rt (
         .clk          (clk),
         .rst          (rst),
         .strobe       (ch_clk_en[i]),
         .master_pulse (master_pulse),
         .pulse_out    (ch_pulse[i])
      );
   end
endmodule

// File: rtl/spg_checker.sv
`timescale 1ns/1ps
module spg_checker #(
   parameter int NUM_CH = 8,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CH-1:0] ch_clk_en,
   input logic [NUM_CH-1:0] ch_loss,
   input logic              master_pulse,
   input logic [NUM_CH-1:0] ch_pulse,
   input logic [IDX_W-1:0]  active_src,
   input logic              all_lost
);
   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   // R3
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
      $past(rst) |-> (!master_pulse && ch_pulse == '0 && active_src == '0));

   // R1
   master_single_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
      master_pulse |=> !master_pulse);

   // R5
   outage_no_pulse_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
      all_lost |=> !master_pulse);

   // R4
   source_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
      !ch_loss[active_src] |=> $stable(active_src));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R7
      retime_edge_only_chk: assert property (@(posedge clk) disable iff (rst || !past_valid)
         !ch_clk_en[i] |=> $stable(ch_pulse[i]));
   end
endmodule

bind sec_pulse_gen spg_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ch_clk_en    (ch_clk_en),
   .ch_loss      (ch_loss),
   .master_pulse (master_pulse),
   .ch_pulse     (ch_pulse),
   .active_src   (active_src),
   .all_lost     (all_lost)
);

// File: tb/sec_pulse_gen_tb.sv
`timescale 1ns/1ps
module sec_pulse_gen_tb;
   localparam int N     = 8;
   localparam int IW    = $clog2(N);
   localparam int DS1C  = 12;
   localparam int CEPTC = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  en = '0;
   logic [N-1:0]  loss = '0;
   logic [N-1:0]  mode = '1;
   logic          master_pulse;
   logic [N-1:0]  ch_pulse;
   logic [IW-1:0] active_src;
   logic          all_lost;

   sec_pulse_gen #(.NUM_CH(N), .DS1_COUNT(DS1C), .CEPT_COUNT(CEPTC)) u_dut (
      .clk(clk), .rst(rst), .ch_clk_en(en), .ch_loss(loss), .ch_mode_ds1(mode),
      .master_pulse(master_pulse), .ch_pulse(ch_pulse),
      .active_src(active_src), .all_lost(all_lost)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [N-1:0] en_mask = '1;
   int pct = 100;
   int pulses = 0;

   // expected state derived from the requirements
   int m_sel = 0;
   int m_cnt = 0;
   bit m_mp = 1'b0;
   bit [N-1:0] m_pend = '0;
   bit [N-1:0] m_out = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] gen_en();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++)
         v[i] = en_mask[i] && ($urandom_range(99) < pct);
      return v;
   endfunction

   task automatic apply_en();
      en = gen_en();
   endtask

   function automatic int next_src(input int cur, input logic [N-1:0] l);
      for (int k = 1; k < N; k++) begin
         if (!l[(cur + k) % N]) return (cur + k) % N;
      end
      return cur;
   endfunction

   task automatic model_step();
      bit tick;
      bit nmp;
      int last;
      if (rst) begin
         m_sel = 0; m_cnt = 0; m_mp = 0; m_pend = '0; m_out = '0;
         return;
      end
      tick = en[m_sel] && !loss[m_sel];
      last = mode[m_sel] ? DS1C - 1 : CEPTC - 1;
      nmp = 1'b0;
      if (tick) begin
         if (m_cnt >= last) begin m_cnt = 0; nmp = 1'b1; end
         else m_cnt++;
      end
      for (int i = 0; i < N; i++) begin
         if (en[i]) begin m_out[i] = m_pend[i]; m_pend[i] = m_mp; end
         else m_pend[i] = m_pend[i] | m_mp;
      end
      if (loss[m_sel] && !(&loss)) m_sel = next_src(m_sel, loss);
      m_mp = nmp;
   endtask

   task automatic cycle();
      @(negedge clk);
      model_step();
      check(master_pulse == m_mp, "R1", "master_pulse", int'(master_pulse), int'(m_mp));
      check(ch_pulse == m_out, "R7", "ch_pulse", int'(ch_pulse), int'(m_out));
      check(int'(active_src) == m_sel, "R4", "active_src", int'(active_src), m_sel);
      check(all_lost == (&loss), "R5", "all_lost", int'(all_lost), int'(&loss));
      if (master_pulse) pulses++;
      en = gen_en();
   endtask

   task automatic gap_to_next(output int g);
      g = 0;
      do begin cycle(); g++; end while (!master_pulse && g < 1000);
   endtask

   initial begin
      int g;
      int p0;
      int guard;
      void'($urandom(32'h5EC0_0D17));
      repeat (3) cycle();
      // R3 reset state
      check(master_pulse == 1'b0 && ch_pulse == '0 && active_src == '0, "R3",
            "reset outputs", int'({master_pulse, ch_pulse, active_src}), 0);
      rst = 1'b0;

      // R1 spacing with DS1 strap, R2 with CEPT strap, source enabled every cycle
      gap_to_next(g);
      gap_to_next(g);
      check(g == DS1C, "R1", "pulse spacing ds1", g, DS1C);
      mode[0] = 1'b0;
      gap_to_next(g);
      check(g == CEPTC, "R2", "pulse spacing cept", g, CEPTC);

      // random densities and straps, no loss
      pct = 35;
      for (int r = 0; r < 8; r++) begin
         mode = N'($urandom);
         repeat (50) cycle();
      end

      // R4 failover order
      pct = 50;
      loss[0] = 1'b1;
      repeat (3) cycle();
      check(active_src == 1, "R4", "step to next", int'(active_src), 1);
      loss[1] = 1'b1; loss[2] = 1'b1;
      repeat (3) cycle();
      check(active_src == 3, "R4", "skip lost", int'(active_src), 3);
      loss = 8'hFE;
      repeat (3) cycle();
      check(active_src == 0, "R4", "wrap to 0", int'(active_src), 0);
      loss = '0;
      repeat (3) cycle();
      loss[0] = 1'b1;
      repeat (2) cycle();
      loss = '0;
      repeat (6) cycle();
      check(active_src == 1, "R4", "no revert", int'(active_src), 1);

      // R5 total outage
      loss = '1; pct = 100; apply_en();
      p0 = pulses;
      repeat (60) cycle();
      check(pulses == p0, "R5", "pulses in outage", pulses - p0, 0);
      check(active_src == 1, "R5", "source held", int'(active_src), 1);
      loss = '0;
      repeat (40) cycle();

      // R6 switch late in a CEPT count onto a DS1 source
      mode[1] = 1'b0; mode[2] = 1'b1;
      en_mask = '0; en_mask[1] = 1'b1; apply_en();
      guard = 0;
      while (m_cnt != 14 && guard < 100) begin cycle(); guard++; end
      check(m_cnt == 14, "R6", "count reached", m_cnt, 14);
      loss[1] = 1'b1;
      en_mask = '0; en_mask[2] = 1'b1; apply_en();
      p0 = pulses;
      repeat (12) cycle();
      check(pulses - p0 == 1, "R6", "pulses after switch", pulses - p0, 1);
      check(active_src == 2, "R6", "new source", int'(active_src), 2);
      loss = '0; en_mask = '1;

      // random loss churn
      pct = 40;
      for (int r = 0; r < 60; r++) begin
         for (int i = 0; i < N; i++) loss[i] = ($urandom_range(99) < 25);
         if (r % 10 == 9) loss = '1;
         mode = N'($urandom);
         apply_en();
         repeat (20) cycle();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule